// File: doc/BRIEF.md
# Hardware-Triggered One-Shot Conversion Sequencer

This block sequences a single-channel analog-to-digital conversion that is started by a hardware event. Software controls it through three write strobes:

- a converter-enable bit;
- a start/status bit, which hardware also sets and clears;
- a channel-select field.

Once enabled, the block waits in trigger standby. Each hardware trigger pulse launches exactly one conversion on the selected channel.

The conversion datapath is represented by a fixed-length cycle count. The sampled value arrives on an input port and is latched into the result register on the final cycle only. Completion raises a one-cycle end-of-conversion pulse and returns the block to standby, still armed.

Several events abort the running conversion and start it again from cycle zero:

- a new trigger;
- any write to the channel field;
- a write of 1 to the start bit.

Writing 0 to the start bit, or clearing the enable bit, abandons the conversion without producing a result.

Top module: `trig_adc_seq`

## Requirements
- R1: While `enBit` is 0, `hwTrig` and writes of 1 to the start bit start nothing and `busy` stays 0. A trigger in the same cycle as the enable write is ignored. Channel writes still update `chanSel`.
- R2: With `enBit`=1 and the block idle, a `hwTrig` pulse sets `busy` on the following cycle. In that same cycle `convStart` is high for exactly one cycle and `convChan` equals the selected channel.
- R3: A conversion that is not disturbed lasts `CONV_CYCLES` busy cycles. `result` takes `sampleData` as it stands in the last busy cycle. `eocIrq` is high for exactly the one cycle after it.
- R4: On completion `busy` returns to 0 and `enBit` stays 1. A later trigger starts a new conversion.
- R5: A trigger during a conversion restarts it on the same channel and counts `CONV_CYCLES` from the restart. The aborted conversion produces no `eocIrq`.
- R6: A channel write during a conversion restarts it on the written channel, even when the value is unchanged. A channel write while idle only updates `chanSel`.
- R7: A start-bit write of 1 restarts a running conversion. While idle and enabled, such a write starts a conversion.
- R8: A start-bit write of 0 during a conversion clears `busy` on the next cycle and pulses `convAbort`. No `eocIrq` is raised, `enBit` stays 1 and the block is back in standby.
- R9: `result` changes only in a completed conversion. This holds even for a restart in the final busy cycle.
- R10: Triggers, channel writes and start writes that land in one cycle cause a single restart, with a single `convStart` pulse. A start-bit write of 0 in that cycle overrides all of them.
- R11: Writing 0 to the enable bit stops a running conversion at once (`busy` 0 next cycle) with no result update and no `eocIrq`.
- R12: After reset `enBit`, `busy`, `convStart`, `convAbort`, `eocIrq` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enWr | input | 1 | Write strobe for the enable bit |
| enVal | input | 1 | Value written to the enable bit |
| startWr | input | 1 | Write strobe for the start/status bit |
| startVal | input | 1 | Value written to the start/status bit |
| chanWr | input | 1 | Write strobe for the channel field |
| chanVal | input | CH_W | Value written to the channel field |
| hwTrig | input | 1 | Hardware trigger, one pulse per event |
| sampleData | input | DATA_W | Converted sample from the datapath |
| enBit | output | 1 | Enable bit readback |
| busy | output | 1 | Start/status bit readback (conversion running) |
| chanSel | output | CH_W | Channel field readback |
| convChan | output | CH_W | Channel of the conversion in progress |
| convStart | output | 1 | One-cycle start or restart strobe to the datapath |
| convAbort | output | 1 | One-cycle strobe for an abort with no restart |
| result | output | DATA_W | Result register |
| eocIrq | output | 1 | One-cycle end-of-conversion interrupt |

## Verification
The hardest case to reach is a restart that lands in the last busy cycle. There the completion and the restart compete at the same edge. The bench counts cycles from its own trigger, so it can place a second trigger on exactly that cycle. It then checks that the pending result is dropped and that the new one arrives a full conversion later. Simultaneous restart sources, and start-bit clears combined with triggers, are driven in a single cycle. The bench then checks that one start pulse, or none at all, follows.

// File: rtl/trig_adc_pkg.sv
package trig_adc_pkg;
  // Strobes from the sequencing control to the result datapath
  typedef struct packed {
    logic launch;  // start or restart a conversion this cycle
    logic cancel;  // abandon the running conversion, no restart
    logic finish;  // last cycle of an undisturbed conversion
  } seqStrobe_t;
endpackage

// File: rtl/trig_adc_ctrl.sv
module trig_adc_ctrl
  import trig_adc_pkg::*;
#(
  parameter int CONV_CYCLES = 8,
  parameter int CH_W        = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enWr,
  input  logic            enVal,
  input  logic            startWr,
  input  logic            startVal,
  input  logic            chanWr,
  input  logic [CH_W-1:0] chanVal,
  input  logic            hwTrig,
  output logic            enBit,
  output logic            busy,
  output logic [CH_W-1:0] chanReg,
  output logic [CH_W-1:0] launchChan,
  output seqStrobe_t      strobe
);
  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic disableNow, stopReq, restartReq, lastCycle;

  always_comb begin
    disableNow = enWr && !enVal;
    stopReq    = startWr && !startVal;
    restartReq = hwTrig || (startWr && startVal) || (chanWr && busy);
    strobe.launch = enBit && !disableNow && !stopReq && restartReq;
    strobe.cancel = busy && !strobe.launch && (disableNow || stopReq);
    strobe.finish = lastCycle && !strobe.launch && !strobe.cancel;
    launchChan    = chanWr ? chanVal : chanReg;
  end

  generate
    if (CONV_CYCLES == 1) begin : g_single
      assign lastCycle = busy;
    end else begin : g_multi
      assign lastCycle = busy && (cnt == LAST);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit   <= 1'b0;
      chanReg <= '0;
      busy    <= 1'b0;
      cnt     <= '0;
    end else begin
      if (enWr)   enBit   <= enVal;
      if (chanWr) chanReg <= chanVal;
      if (strobe.launch) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (strobe.cancel || strobe.finish) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/trig_adc_dpath.sv
module trig_adc_dpath
  import trig_adc_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [CH_W-1:0]   launchChan,
  input  logic [DATA_W-1:0] sampleData,
  output logic              convStart,
  output logic              convAbort,
  output logic [CH_W-1:0]   convChan,
  output logic [DATA_W-1:0] result,
  output logic              eocIrq
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convStart <= 1'b0;
      convAbort <= 1'b0;
      convChan  <= '0;
      result    <= '0;
      eocIrq    <= 1'b0;
    end else begin
      convStart <= strobe.launch;
      convAbort <= strobe.cancel;
      eocIrq    <= strobe.finish;
      if (strobe.launch) convChan <= launchChan;
      if (strobe.finish) result   <= sampleData;
    end
  end
endmodule

// File: rtl/trig_adc_seq.sv
module trig_adc_seq
  import trig_adc_pkg::*;
#(
  parameter int CONV_CYCLES = 8,
  parameter int DATA_W      = 10,
  parameter int CH_W        = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enWr,
  input  logic              enVal,
  input  logic              startWr,
  input  logic              startVal,
  input  logic              chanWr,
  input  logic [CH_W-1:0]   chanVal,
  input  logic              hwTrig,
  input  logic [DATA_W-1:0] sampleData,
  output logic              enBit,
  output logic              busy,
  output logic [CH_W-1:0]   chanSel,
  output logic [CH_W-1:0]   convChan,
  output logic              convStart,
  output logic              convAbort,
  output logic [DATA_W-1:0] result,
  output logic              eocIrq
);
  seqStrobe_t      strobe;
  logic [CH_W-1:0] launchChan;

  trig_adc_ctrl #(.CONV_CYCLES(CONV_CYCLES), .CH_W(CH_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .enWr(enWr), .enVal(enVal),
    .startWr(startWr), .startVal(startVal),
    .chanWr(chanWr), .chanVal(chanVal),
    .hwTrig(hwTrig),
    .enBit(enBit), .busy(busy), .chanReg(chanSel),
    .launchChan(launchChan), .strobe(strobe)
  );

  trig_adc_dpath #(.DATA_W(DATA_W), .CH_W(CH_W)) u_dpath (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .launchChan(launchChan), .sampleData(sampleData),
    .convStart(convStart), .convAbort(convAbort), .convChan(convChan),
    .result(result), .eocIrq(eocIrq)
  );
endmodule

// File: rtl/trig_adc_checker.sv
module trig_adc_checker #(
  parameter int CONV_CYCLES = 8,
  parameter int DATA_W      = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              enBit,
  input logic              busy,
  input logic              convStart,
  input logic              convAbort,
  input logic [DATA_W-1:0] result,
  input logic              eocIrq
);
  localparam int K_W = $clog2(CONV_CYCLES + 1) + 1;
  localparam logic [K_W-1:0] K_DONE = K_W'(CONV_CYCLES);

  // busy cycles since the latest start strobe
  logic [K_W-1:0] runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          runLen <= '0;
    else if (!busy)     runLen <= '0;
    else if (convStart) runLen <= K_W'(1);
    else                runLen <= runLen + 1'b1;
  end

  a_r1_idle_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enBit |-> !busy);
  a_r2_start_marks_busy: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> busy);
  a_r3_eoc_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    eocIrq |=> !eocIrq);
  a_r3_conversion_length: assert property (@(posedge clk) disable iff (!rstN)
    eocIrq |-> (runLen == K_DONE));
  a_r4_eoc_leaves_idle: assert property (@(posedge clk) disable iff (!rstN)
    eocIrq |-> (!busy && enBit));
  a_r8_abort_is_quiet: assert property (@(posedge clk) disable iff (!rstN)
    convAbort |-> (!busy && !eocIrq));
  a_r9_result_only_on_eoc: assert property (@(posedge clk) disable iff (!rstN)
    !eocIrq |-> $stable(result));
endmodule

bind trig_adc_seq trig_adc_checker #(.CONV_CYCLES(CONV_CYCLES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .enBit(enBit), .busy(busy),
  .convStart(convStart), .convAbort(convAbort), .result(result), .eocIrq(eocIrq)
);

// File: tb/test_trig_adc_seq.sv
module test_trig_adc_seq;
  localparam int N  = 8;
  localparam int DW = 10;
  localparam int CW = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic rstN, enWr, enVal, startWr, startVal, chanWr, hwTrig;
  logic [CW-1:0] chanVal, chanSel, convChan;
  logic [DW-1:0] sampleData, result;
  logic enBit, busy, convStart, convAbort, eocIrq;

  trig_adc_seq #(.CONV_CYCLES(N), .DATA_W(DW), .CH_W(CW)) i_trig_adc_seq (
    .clk(clk), .rstN(rstN), .enWr(enWr), .enVal(enVal),
    .startWr(startWr), .startVal(startVal), .chanWr(chanWr), .chanVal(chanVal),
    .hwTrig(hwTrig), .sampleData(sampleData),
    .enBit(enBit), .busy(busy), .chanSel(chanSel), .convChan(convChan),
    .convStart(convStart), .convAbort(convAbort), .result(result), .eocIrq(eocIrq)
  );

  typedef struct {
    int ch;
    int data;
    int due;
  } item_t;
  item_t q[$];

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN && eocIrq) begin
      if (q.size() == 0) begin
        chk("R9 eocIrq with no conversion pending", 1, 0);
      end else begin
        item_t it;
        it = q.pop_front();
        chk("R3 result value", int'(result), it.data);
        chk("R3 completion cycle", cyc, it.due);
        chk("R6 channel of completed conversion", int'(convChan), it.ch);
      end
    end
  end

  // Expect a conversion that the next drive() call launches (called at a negedge)
  task automatic expect_conv(input int ch, input int data);
    item_t it;
    it.ch = ch; it.data = data; it.due = cyc + 1 + N;
    sampleData = DW'(data);
    q.push_back(it);
  endtask

  task automatic drop_pending();
    void'(q.pop_back());
  endtask

  // Apply strobes for one cycle; entered and left at a negedge
  task automatic drive(input logic t, input logic sw, input logic sv,
                       input logic cw, input int cv, input logic ew, input logic ev);
    hwTrig = t; startWr = sw; startVal = sv; chanWr = cw; chanVal = CW'(cv);
    enWr = ew; enVal = ev;
    @(negedge clk);
    hwTrig = 0; startWr = 0; startVal = 0; chanWr = 0; enWr = 0; enVal = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk("watchdog expired", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int held;
    rstN = 0; enWr = 0; enVal = 0; startWr = 0; startVal = 0; chanWr = 0;
    chanVal = '0; hwTrig = 0; sampleData = '0;
    wait_n(3);
    rstN = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 enBit", int'(enBit), 0);
    chk("R12 busy", int'(busy), 0);
    chk("R12 result", int'(result), 0);
    chk("R12 eocIrq", int'(eocIrq), 0);
    chk("R12 convStart", int'(convStart), 0);
    chk("R12 convAbort", int'(convAbort), 0);

    // R1 disabled: trigger, start write and trigger+enable are ignored
    drive(1, 0, 0, 0, 0, 0, 0);
    chk("R1 trigger ignored", int'(busy), 0);
    drive(0, 1, 1, 0, 0, 0, 0);
    chk("R1 start write ignored", int'(busy), 0);
    drive(0, 0, 0, 1, 5, 0, 0);
    chk("R1 channel write accepted", int'(chanSel), 5);
    drive(1, 0, 0, 0, 0, 1, 1);
    chk("R1 trigger with enable write ignored", int'(busy), 0);
    chk("R1 enable set", int'(enBit), 1);
    wait_n(N + 2);
    chk("R1 still idle", int'(busy), 0);

    // R2/R3 basic conversion
    expect_conv(5, 'h155);
    drive(1, 0, 0, 0, 0, 0, 0);
    chk("R2 busy set", int'(busy), 1);
    chk("R2 convStart pulse", int'(convStart), 1);
    chk("R2 convChan", int'(convChan), 5);
    wait_n(1);
    chk("R2 convStart one cycle", int'(convStart), 0);
    wait_n(N + 1);
    chk("R4 busy cleared", int'(busy), 0);
    chk("R4 still enabled", int'(enBit), 1);
    chk("R3 queue drained", q.size(), 0);

    // R6 idle channel write, R4 rearmed
    drive(0, 0, 0, 1, 2, 0, 0);
    chk("R6 idle channel write no start", int'(busy), 0);
    chk("R6 chanSel", int'(chanSel), 2);
    expect_conv(2, 'h2aa);
    drive(1, 0, 0, 0, 0, 0, 0);
    chk("R4 second trigger accepted", int'(busy), 1);
    wait_n(N + 2);

    // R5 retrigger mid-conversion
    expect_conv(2, 'h011);
    drive(1, 0, 0, 0, 0, 0, 0);
    wait_n(3);
    drop_pending();
    expect_conv(2, 'h0f0);
    drive(1, 0, 0, 0, 0, 0, 0);
    chk("R5 restart strobe", int'(convStart), 1);
    wait_n(N + 2);
    chk("R5 queue drained", q.size(), 0);

    // R6 channel write with same value, then a new value
    expect_conv(2, 'h001);
    drive(1, 0, 0, 0, 0, 0, 0);
    wait_n(2);
    drop_pending();
    expect_conv(2, 'h123);
    drive(0, 0, 0, 1, 2, 0, 0);
    chk("R6 same-value write restarts", int'(convStart), 1);
    wait_n(N + 2);
    expect_conv(2, 'h002);
    drive(1, 0, 0, 0, 0, 0, 0);
    wait_n(4);
    drop_pending();
    expect_conv(6, 'h321);
    drive(0, 0, 0, 1, 6, 0, 0);
    chk("R6 new channel", int'(convChan), 6);
    wait_n(N + 2);

    // R7 start write 1 mid-conversion and while idle
    expect_conv(6, 'h003);
    drive(1, 0, 0, 0, 0, 0, 0);
    wait_n(5);
    drop_pending();
    expect_conv(6, 'h0aa);
    drive(0, 1, 1, 0, 0, 0, 0);
    chk("R7 restart strobe", int'(convStart), 1);
    wait_n(N + 2);
    expect_conv(6, 'h0bb);
    drive(0, 1, 1, 0, 0, 0, 0);
    chk("R7 idle start write", int'(busy), 1);
    wait_n(N + 2);

    // R8 start write 0 mid-conversion
    held = int'(result);
    expect_conv(6, 'h004);
    drive(1, 0, 0, 0, 0, 0, 0);
    wait_n(4);
    drop_pending();
    drive(0, 1, 0, 0, 0, 0, 0);
    chk("R8 busy cleared", int'(busy), 0);
    chk("R8 convAbort", int'(convAbort), 1);
    chk("R8 enabled", int'(enBit), 1);
    wait_n(N + 2);
    chk("R9 result kept after abort", int'(result), held);

    // R9 restart in the final busy cycle
    expect_conv(6, 'h005);
    drive(1, 0, 0, 0, 0, 0, 0);
    wait_n(N - 1);
    chk("R9 still busy in final cycle", int'(busy), 1);
    drop_pending();
    expect_conv(6, 'h1ee);
    drive(1, 0, 0, 0, 0, 0, 0);
    chk("R9 no eocIrq on final-cycle restart", int'(eocIrq), 0);
    chk("R9 result unchanged", int'(result), held);
    wait_n(N + 2);
    chk("R9 result from restarted conversion", int'(result), 'h1ee);

    // R10 simultaneous sources: one restart
    expect_conv(6, 'h006);
    drive(1, 0, 0, 0, 0, 0, 0);
    wait_n(3);
    drop_pending();
    expect_conv(4, 'h0cc);
    drive(1, 1, 1, 1, 4, 0, 0);
    chk("R10 single restart strobe", int'(convStart), 1);
    wait_n(1);
    chk("R10 strobe not repeated", int'(convStart), 0);
    wait_n(N + 1);
    held = int'(result);
    // stop beats trigger while busy
    expect_conv(4, 'h007);
    drive(1, 0, 0, 0, 0, 0, 0);
    wait_n(3);
    drop_pending();
    drive(1, 1, 0, 0, 0, 0, 0);
    chk("R10 stop overrides trigger", int'(busy), 0);
    chk("R10 no restart strobe", int'(convStart), 0);
    // stop beats trigger while idle
    drive(1, 1, 0, 0, 0, 0, 0);
    chk("R10 idle stop overrides trigger", int'(busy), 0);
    wait_n(N + 2);
    chk("R10 result unchanged", int'(result), held);

    // R11 enable cleared mid-conversion
    expect_conv(4, 'h008);
    drive(1, 0, 0, 0, 0, 0, 0);
    wait_n(4);
    drop_pending();
    drive(0, 0, 0, 0, 0, 1, 0);
    chk("R11 enBit cleared", int'(enBit), 0);
    chk("R11 busy cleared", int'(busy), 0);
    wait_n(N + 2);
    chk("R11 result unchanged", int'(result), held);
    drive(1, 0, 0, 0, 0, 0, 0);
    chk("R1 trigger ignored after disable", int'(busy), 0);
    wait_n(N + 2);

    chk("R3 all expected results seen", q.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule